// File: doc/BRIEF.md
# Two-Wire Register Bank Target with Auto-Increment

This block is a target on a two-wire I2C bus. Through it, a host reads and writes a bank of 16-bit registers. Each register has a 16-bit address. Every address and every data word crosses the bus as two bytes, with the high byte first.

An access starts with the target's 7-bit device address. A write-mode access then carries a two-byte register address and any number of two-byte data words. Each completed word is written to the register the pointer names, and then the pointer advances by one. A read-mode access returns words starting at the current pointer. The pointer advances after every pair, so a host can stream through consecutive registers. The pointer keeps its value between transactions, so a later read with no address phase continues where the earlier one stopped.

The bus lines are sampled into the system clock domain. The target drives SDA only through an open-drain enable: it pulls the line low or lets it float. Register traffic appears on a plain strobe port, which an internal array of registers serves. A START or STOP that arrives part way through an access ends that access at once.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset the target releases SDA (`sda_oe` = 0) and raises neither the write strobe nor the read strobe until the bus addresses it.
- R2: The first byte after a START holds the 7-bit device address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). When the address differs from `DEV_ADDR`, the target never pulls SDA low for the ACK or later, and no register changes before the next START.
- R3: In a write-mode access, the target pulls SDA low in the ACK slot of every byte: the device address, both address bytes and every data byte.
- R4: The register address is the first two bytes after the write-mode device address, high byte first. A data word is the next two bytes, high byte first. Bit 7 of each byte travels first.
- R5: In a write-mode access, data pairs may follow one another without a STOP. The k-th pair (k = 0, 1, …) is written to the start address plus k.
- R6: A read made of a write-mode address phase, a repeated START and the read-mode device address returns the register at that address, high byte first, on SDA.
- R7: In a read, the host may ACK further bytes. Each pair then comes from the next register. The pointer advances after the low byte of every pair, whether the host ACKs or NACKs that byte.
- R8: A read-mode access that starts with no new address phase returns data from the current pointer and keeps incrementing from there.
- R9: A START or STOP that arrives part way through an access ends it. A data pair that has only its high byte received is discarded, and no register changes.
- R10: The write strobe pulses for exactly one cycle, only after the ACK slot of the low data byte has ended. The pointer is one higher in the next cycle.
- R11: The target changes its SDA drive only while SCL is low. SDA therefore holds steady during every SCL high phase of a byte the target sends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 lets the line float |
| reg_addr | output | 16 | Register address for the current access |
| reg_wdata | output | 16 | Write data, valid while `reg_we` is high |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle strobe marking a read-data capture |
| reg_rdata | output | 16 | Data the register array returns for `reg_addr` |

## Verification
The checker holds several rules on every cycle: SDA drive changes only while the synchronized SCL is low, a STOP releases the line in the next cycle, each write strobe moves the pointer up by exactly one, and the two strobes never fire together. Other behaviour only the directed scenarios can show. These cover byte order on the wire, an address mismatch leaving the bus silent, burst writes landing on consecutive registers, reads that continue after an earlier NACKed pair, and aborted half pairs leaving the bank unchanged. The bench shows them by comparing ACK bits, strobe payloads and words read back against values it computes itself.

// File: rtl/i2c_rb_pkg.sv
// Package: shared widths and state encodings for the register-bank target.
// Assumes byte-wide bus transfers that make up 16-bit words.
package i2c_rb_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    // Bit-level bus engine state
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_t;

    // Which byte of a write-mode access comes next
    typedef enum logic [2:0] {
        PH_DEV,
        PH_AH,
        PH_AL,
        PH_DH,
        PH_DL
    } phase_t;
endpackage

// File: rtl/i2c_rb_sync.sv
// Module: brings SCL/SDA into the clock domain and flags bus conditions.
// Assumes both lines idle high and the system clock runs many times faster
// than SCL. START = SDA falls while SCL high; STOP = SDA rises while SCL high.
module i2c_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    // Synchronizer chains, reset to the idle-high bus level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // One-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rb_engine.sv
// Module: byte/ACK engine, address pointer and register strobes.
// Assumes clean edge flags from i2c_rb_sync. Has no clock stretching.
// Drives SDA only on SCL falls. Read data is combinational from rdata.
module i2c_rb_engine
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [WORD_W-1:0] rdata,
    output logic              sda_oe,
    output logic [WORD_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    output logic [WORD_W-1:0] ptr_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    bus_state_t        state;
    phase_t            phase;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw;
    logic [WORD_W-1:0] ptr;
    logic [BYTE_W-1:0] ptr_hi;
    logic [BYTE_W-1:0] dat_hi;
    logic [WORD_W-1:0] tx_sh;
    logic              tx_lo;
    logic              host_ack;

    logic rx_ack_end;
    logic tx_ack_end;
    logic rd_first;
    logic rd_next;

    // Decode the cycles in which a strobe fires
    always_comb begin
        rx_ack_end = (state == ST_RX_ACK) && scl_fall;
        tx_ack_end = (state == ST_TX_ACK) && scl_fall;
        reg_we     = rx_ack_end && (phase == PH_DL);
        rd_first   = rx_ack_end && (phase == PH_DEV) && rw;
        rd_next    = tx_ack_end && tx_lo && host_ack;
        reg_re     = rd_first || rd_next;
    end

    // Present the next register early when a read pair rolls over
    always_comb begin
        reg_addr  = rd_next ? ptr + WORD_W'(1) : ptr;
        reg_wdata = {dat_hi, shreg};
    end

    assign ptr_o = ptr;

    // Main protocol sequencer; START and STOP take priority over everything
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= PH_DEV;
            bitcnt   <= '0;
            shreg    <= '0;
            rw       <= 1'b0;
            ptr      <= '0;
            ptr_hi   <= '0;
            dat_hi   <= '0;
            tx_sh    <= '0;
            tx_lo    <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (start_det) begin
            state  <= ST_RX;
            phase  <= PH_DEV;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + CNT_W'(1);
                    end else if (scl_fall && bitcnt == LAST_BIT) begin
                        if (phase == PH_DEV) begin
                            if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                rw     <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_RX_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            sda_oe <= 1'b1;
                            state  <= ST_RX_ACK;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_RX;
                        case (phase)
                            PH_DEV: begin
                                if (rw) begin
                                    sda_oe <= ~rdata[WORD_W-1];
                                    tx_sh  <= {rdata[WORD_W-2:0], 1'b0};
                                    tx_lo  <= 1'b0;
                                    state  <= ST_TX;
                                end else begin
                                    phase <= PH_AH;
                                end
                            end
                            PH_AH: begin
                                ptr_hi <= shreg;
                                phase  <= PH_AL;
                            end
                            PH_AL: begin
                                ptr   <= {ptr_hi, shreg};
                                phase <= PH_DH;
                            end
                            PH_DH: begin
                                dat_hi <= shreg;
                                phase  <= PH_DL;
                            end
                            default: begin
                                ptr   <= ptr + WORD_W'(1);
                                phase <= PH_DH;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + CNT_W'(1);
                    end else if (scl_fall) begin
                        if (bitcnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else begin
                            sda_oe <= ~tx_sh[WORD_W-1];
                            tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        bitcnt <= '0;
                        if (!tx_lo) begin
                            if (host_ack) begin
                                sda_oe <= ~tx_sh[WORD_W-1];
                                tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
                                tx_lo  <= 1'b1;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            ptr <= ptr + WORD_W'(1);
                            if (host_ack) begin
                                sda_oe <= ~rdata[WORD_W-1];
                                tx_sh  <= {rdata[WORD_W-2:0], 1'b0};
                                tx_lo  <= 1'b0;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_rb_regs.sv
// Module: small register array that serves the strobe port in tests.
// Assumes index = low address bits (aliasing above N_REGS); async read.
module i2c_rb_regs
    import i2c_rb_pkg::*;
#(
    parameter int N_REGS = 16,
    localparam int IDX_W = $clog2(N_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              we,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [N_REGS];

    // Storage: cleared on reset, one word written per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REGS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/i2c_regbank_slave.sv
// Module: top of the two-wire register-bank target.
// Assumes an external pull-up on SDA; sda_oe=1 means pull the pad low.
module i2c_regbank_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         N_REGS      = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic [15:0] reg_addr,
    output logic [15:0] reg_wdata,
    output logic        reg_we,
    output logic        reg_re,
    output logic [15:0] reg_rdata
);
    localparam int IDX_W = $clog2(N_REGS);

    logic        scl_s;
    logic        sda_s;
    logic        scl_rise;
    logic        scl_fall;
    logic        start_det;
    logic        stop_det;
    logic [15:0] ptr;

    i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rb_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rdata     (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .ptr_o     (ptr)
    );

    i2c_rb_regs #(.N_REGS(N_REGS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (reg_addr[IDX_W-1:0]),
        .wdata (reg_wdata),
        .we    (reg_we),
        .rdata (reg_rdata)
    );
endmodule

// File: rtl/i2c_rb_checker.sv
// Module: cycle-level properties of the register-bank target, bound to the top.
// Assumes visibility of the top's synchronized SCL, STOP flag and pointer.
module i2c_rb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_s,
    input logic        stop_det,
    input logic        sda_oe,
    input logic        reg_we,
    input logic        reg_re,
    input logic [15:0] ptr
);
    // R11: SDA drive changes only while SCL is low
    a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R9: a STOP releases the line in the next cycle
    a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R10: each write strobe advances the pointer by exactly one
    a_r10_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (ptr == $past(ptr) + 16'd1));

    // R7: a read capture and a write never share a cycle
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, reg_re}));

    // R1: the target never pulls SDA in the cycle that follows a reset cycle
    a_r1_reset_release: assert property (@(posedge clk)
        !rst_n |=> !sda_oe);
endmodule

bind i2c_regbank_slave i2c_rb_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .ptr      (ptr)
);

// File: tb/i2c_regbank_slave_tb.sv
module i2c_regbank_slave_tb;
    localparam int Q = 6;
    localparam logic [7:0] DW = 8'h54;
    localparam logic [7:0] DR = 8'h55;
    localparam logic [7:0] DBAD = 8'h56;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        host_sda = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [15:0] reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_we;
    logic        reg_re;
    logic [15:0] reg_rdata;

    int          n_chk = 0;
    int          n_bad = 0;
    int          we_count = 0;
    int          stable_err = 0;
    logic [15:0] last_waddr = '0;
    logic [15:0] last_wdata = '0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = host_sda & ~sda_oe;

    i2c_regbank_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata)
    );

    // Log the write strobes the block raises
    always @(posedge clk) begin
        if (rst_n && reg_we) begin
            we_count   <= we_count + 1;
            last_waddr <= reg_addr;
            last_wdata <= reg_wdata;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; wq(1);
        scl = 1'b1;      wq(1);
        host_sda = 1'b0; wq(1);
        scl = 1'b0;      wq(1);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wq(1);
        scl = 1'b1;      wq(1);
        host_sda = 1'b1; wq(1);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; wq(1);
            scl = 1'b1;      wq(2);
            scl = 1'b0;
        end
        wq(1);
        host_sda = 1'b1; wq(1);
        scl = 1'b1;      wq(1);
        acked = !sda_line;
        wq(1);
        scl = 1'b0;      wq(1);
    endtask

    task automatic get_byte(output logic [7:0] b, input bit ack);
        logic s1;
        for (int i = 7; i >= 0; i--) begin
            host_sda = 1'b1; wq(1);
            scl = 1'b1;      wq(1);
            s1 = sda_line;   wq(1);
            if (s1 !== sda_line) stable_err++;
            b[i] = s1;
            scl = 1'b0;
        end
        wq(1);
        host_sda = ack ? 1'b0 : 1'b1; wq(1);
        scl = 1'b1; wq(2);
        scl = 1'b0; wq(1);
    endtask

    task automatic get_word(output logic [15:0] w, input bit last);
        logic [7:0] hi;
        logic [7:0] lo;
        get_byte(hi, 1'b1);
        get_byte(lo, !last);
        w = {hi, lo};
    endtask

    // START, write-mode device address, two address bytes; R3 ACKs checked
    task automatic addr_phase(input logic [15:0] a);
        bit k;
        bus_start();
        put_byte(DW, k);      check("R3", "ack dev", k, 1);
        put_byte(a[15:8], k); check("R3", "ack addr hi", k, 1);
        put_byte(a[7:0], k);  check("R3", "ack addr lo", k, 1);
    endtask

    task automatic t_reset();
        check("R1", "sda_oe after reset", sda_oe, 0);
        check("R1", "no strobes after reset", we_count, 0);
    endtask

    task automatic t_bad_addr();
        bit k;
        int c0 = we_count;
        bus_start();
        put_byte(DBAD, k); check("R2", "no ack wrong dev", k, 0);
        put_byte(8'h00, k);
        put_byte(8'h03, k);
        put_byte(8'h12, k);
        put_byte(8'h34, k); check("R2", "silent after mismatch", k, 0);
        bus_stop();
        check("R2", "no write after mismatch", we_count, c0);
    endtask

    task automatic t_write_single();
        bit k;
        int c0 = we_count;
        addr_phase(16'h0003);
        put_byte(8'hA5, k); check("R3", "ack data hi", k, 1);
        check("R10", "no strobe after high byte", we_count, c0);
        put_byte(8'hC3, k); check("R3", "ack data lo", k, 1);
        check("R10", "one strobe after low byte", we_count, c0 + 1);
        check("R4", "write address", last_waddr, 16'h0003);
        check("R4", "write data", last_wdata, 16'hA5C3);
        bus_stop();
    endtask

    task automatic t_write_burst();
        bit k;
        int c0 = we_count;
        addr_phase(16'h0006);
        put_byte(8'h11, k); put_byte(8'h11, k);
        check("R5", "first pair address", last_waddr, 16'h0006);
        put_byte(8'h22, k); put_byte(8'h22, k);
        check("R5", "second pair address", last_waddr, 16'h0007);
        put_byte(8'h33, k); put_byte(8'h33, k);
        check("R5", "third pair address", last_waddr, 16'h0008);
        check("R5", "third pair data", last_wdata, 16'h3333);
        check("R5", "three strobes", we_count, c0 + 3);
        bus_stop();
    endtask

    task automatic t_abort();
        bit k;
        logic [15:0] w;
        int c0 = we_count;
        addr_phase(16'h0003);
        put_byte(8'hFF, k);
        bus_stop();
        check("R9", "half pair before STOP dropped", we_count, c0);
        addr_phase(16'h0004);
        put_byte(8'h77, k);
        addr_phase(16'h0003);
        bus_start();
        put_byte(DR, k);
        get_word(w, 1'b1);
        bus_stop();
        check("R9", "half pair before START dropped", we_count, c0);
        check("R9", "register unchanged", w, 16'hA5C3);
    endtask

    task automatic t_read_single();
        bit k;
        logic [15:0] w;
        addr_phase(16'h0003);
        bus_start();
        put_byte(DR, k); check("R6", "ack read dev", k, 1);
        get_word(w, 1'b1);
        bus_stop();
        check("R6", "single read word", w, 16'hA5C3);
    endtask

    task automatic t_read_burst();
        bit k;
        logic [15:0] w;
        addr_phase(16'h0006);
        bus_start();
        put_byte(DR, k);
        get_word(w, 1'b0); check("R7", "burst word 0", w, 16'h1111);
        get_word(w, 1'b1); check("R7", "burst word 1", w, 16'h2222);
        bus_stop();
    endtask

    task automatic t_read_continue();
        bit k;
        logic [15:0] w;
        bus_start();
        put_byte(DR, k); check("R8", "ack continuing read", k, 1);
        get_word(w, 1'b0); check("R8", "continue at n+2", w, 16'h3333);
        get_word(w, 1'b1); check("R8", "continue at n+3", w, 16'h0000);
        bus_stop();
        check("R11", "SDA steady while SCL high", stable_err, 0);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_reset();
        t_bad_addr();
        t_write_single();
        t_write_burst();
        t_abort();
        t_read_single();
        t_read_burst();
        t_read_continue();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule